// File: doc/BRIEF.md
# DQS Write-Leveling Delay Sweeper

This block finds, for every DQS group of a DRAM interface, the DQS launch delay at which the strobe lines up with the memory clock at the device. A start pulse makes it issue one mode-register write that puts the DRAM into leveling mode. It then sets all group delay codes to zero. From there it raises the shared sweep code one step (1/32 UI) at a time. After each code change it waits a few settle cycles. It then requests a fixed, odd number of strobe pulses and takes a majority vote over the feedback bit that each group returns.

Each group stops at the first code whose vote is 1 directly after a vote of 0, and keeps that code. The sweep ends when every group has locked, or after the last code. A group with no such transition is flagged in its error bit and parked at code 0. A second mode-register write then takes the DRAM out of leveling mode, and after a short wait the block raises done. The delay line and the DRAM are outside the block.

Top module: `wlv_sweeper`

## Requirements
- R1: Out of reset `done_o`, `err_o`, `mr_wr_o` and `pulse_o` are 0 and every group delay code is 0.
- R2: A start pulse while idle or done causes exactly one single-cycle `mr_wr_o` with `mr_addr_o` = 1 and `mr_data_o` = MR1_BASE with bit 7 set. This write happens before any `pulse_o`, and every group code reads 0 before the first pulse.
- R3: Unlocked groups share one sweep code that starts at 0 and rises by exactly 1 per step. After any code change, `pulse_o` stays low for at least SETTLE cycles.
- R4: Each code step makes exactly NSAMP pulse cycles, and `fb_i` is sampled at the clock edge that ends each pulse cycle. A group's vote for the step is 1 when more than half of its samples are 1, so isolated wrong samples are rejected.
- R5: A group locks at the first code c ≥ 1 whose vote is 1 while the vote at c−1 was 0. Its output then holds c, and votes of 1 at code 0 or before a 0 do not lock.
- R6: A group with no such transition by code 31 gets its `err_o` bit set, and its code is 0 while `done_o` is high.
- R7: The sweep stops after the step in which the last group locks. Exactly one `mr_wr_o` then follows, with address 1 and MR1_BASE with bit 7 cleared, and `done_o` rises after it. No pulse or mode write occurs while `done_o` is high.
- R8: `done_o`, `err_o` and all codes hold until the next start. A start pulse during a sweep is ignored, and a start pulse while done clears `done_o` and runs a new sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a leveling run (single-cycle pulse) |
| mr_wr_o | output | 1 | Mode-register write strobe |
| mr_addr_o | output | MRA_W | Mode-register address |
| mr_data_o | output | MRD_W | Mode-register write data |
| pulse_o | output | 1 | Request one DQS pulse this cycle |
| fb_i | input | NGRP | Per-group leveling feedback, sampled at the end of each pulse cycle |
| dly_code_o | output | NGRP*CW | Per-group DQS delay codes, group g at [g*CW +: CW] |
| err_o | output | NGRP | Per-group no-transition flag |
| done_o | output | 1 | Run complete; leveling mode left |

## Verification
The bound checker watches, on every cycle, the settle gap after each code change and the pulse count per step. It also checks that no pulse coincides with a mode write, that nothing is issued and no code moves while done is high, and that flagged groups sit at code 0. Only the bench scenarios can show where each group locks. The bench feeds group edges at both ends of the code range, a feedback that is already high at code 0 and drops before rising again, noisy samples, an early end of the sweep, the order and data of the two mode writes, and the handling of a start pulse during a run.

// File: rtl/wlv_pkg.sv
package wlv_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_MR_ON,
    S_MR_ON_W,
    S_SETTLE,
    S_SAMPLE,
    S_EVAL,
    S_MR_OFF,
    S_MR_OFF_W,
    S_DONE
  } wlv_state_e;
endpackage

// File: rtl/wlv_vote.sv
// Counts ones over one step's samples and reports the majority.
module wlv_vote #(
  parameter int unsigned NSAMP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic smp_en,
  input  logic fb,
  output logic maj
);
  localparam int unsigned VW = $clog2(NSAMP + 1);

  logic [VW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else if (smp_en && fb) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign maj = ((32'(cnt_q)) * 2) > NSAMP;
endmodule

// File: rtl/wlv_lane.sv
// Per-group transition search and lock.
module wlv_lane #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic          fin,
  input  logic          vote,
  input  logic [CW-1:0] sweep_code,
  output logic          hit,
  output logic          locked,
  output logic          err,
  output logic [CW-1:0] code_o
);
  logic          have_prev_q, have_prev_d;
  logic          prev_q, prev_d;
  logic          locked_q, locked_d;
  logic          err_q, err_d;
  logic [CW-1:0] lock_code_q, lock_code_d;

  assign hit = upd && !locked_q && have_prev_q && !prev_q && vote;

  always_comb begin
    have_prev_d = have_prev_q;
    prev_d      = prev_q;
    locked_d    = locked_q;
    err_d       = err_q;
    lock_code_d = lock_code_q;
    if (clr) begin
      have_prev_d = 1'b0;
      prev_d      = 1'b0;
      locked_d    = 1'b0;
      err_d       = 1'b0;
      lock_code_d = '0;
    end else if (upd && !locked_q) begin
      have_prev_d = 1'b1;
      prev_d      = vote;
      if (hit) begin
        locked_d    = 1'b1;
        lock_code_d = sweep_code;
      end else if (fin) begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_q      <= 1'b0;
      locked_q    <= 1'b0;
      err_q       <= 1'b0;
      lock_code_q <= '0;
    end else begin
      have_prev_q <= have_prev_d;
      prev_q      <= prev_d;
      locked_q    <= locked_d;
      err_q       <= err_d;
      lock_code_q <= lock_code_d;
    end
  end

  assign locked = locked_q;
  assign err    = err_q;
  assign code_o = locked_q ? lock_code_q : (err_q ? '0 : sweep_code);
endmodule

// File: rtl/wlv_seq.sv
// Run sequencer: mode writes, settle waits, pulse bursts, sweep code.
module wlv_seq
  import wlv_pkg::*;
#(
  parameter int unsigned CODES  = 32,
  parameter int unsigned NSAMP  = 5,
  parameter int unsigned SETTLE = 3,
  parameter int unsigned MRD    = 4,
  localparam int unsigned CW    = $clog2(CODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          all_lock,
  output logic          mr_wr,
  output logic          mr_on,
  output logic          pulse,
  output logic          smp_clr,
  output logic          upd,
  output logic          fin,
  output logic          clr,
  output logic          done,
  output logic [CW-1:0] code
);
  localparam int unsigned M1 = (NSAMP > SETTLE) ? NSAMP : SETTLE;
  localparam int unsigned M2 = (M1 > MRD) ? M1 : MRD;
  localparam int unsigned WW = $clog2(M2 + 1);

  wlv_state_e    st_q, st_d;
  logic [WW-1:0] wc_q, wc_d;
  logic [CW-1:0] code_q, code_d;
  logic          last_code;

  assign last_code = (code_q == CW'(CODES - 1));

  always_comb begin
    st_d    = st_q;
    wc_d    = wc_q;
    code_d  = code_q;
    mr_wr   = 1'b0;
    mr_on   = 1'b0;
    pulse   = 1'b0;
    smp_clr = 1'b0;
    upd     = 1'b0;
    fin     = 1'b0;
    clr     = 1'b0;
    unique case (st_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          clr    = 1'b1;
          code_d = '0;
          st_d   = S_MR_ON;
        end
      end
      S_MR_ON: begin
        mr_wr = 1'b1;
        mr_on = 1'b1;
        wc_d  = '0;
        st_d  = S_MR_ON_W;
      end
      S_MR_ON_W: begin
        wc_d = wc_q + 1'b1;
        if (wc_q == WW'(MRD - 1)) begin
          wc_d = '0;
          st_d = S_SETTLE;
        end
      end
      S_SETTLE: begin
        smp_clr = 1'b1;
        wc_d    = wc_q + 1'b1;
        if (wc_q == WW'(SETTLE - 1)) begin
          wc_d = '0;
          st_d = S_SAMPLE;
        end
      end
      S_SAMPLE: begin
        pulse = 1'b1;
        wc_d  = wc_q + 1'b1;
        if (wc_q == WW'(NSAMP - 1)) begin
          wc_d = '0;
          st_d = S_EVAL;
        end
      end
      S_EVAL: begin
        upd = 1'b1;
        fin = last_code || all_lock;
        if (fin) begin
          st_d = S_MR_OFF;
        end else begin
          code_d = code_q + 1'b1;
          st_d   = S_SETTLE;
        end
      end
      S_MR_OFF: begin
        mr_wr = 1'b1;
        wc_d  = '0;
        st_d  = S_MR_OFF_W;
      end
      S_MR_OFF_W: begin
        wc_d = wc_q + 1'b1;
        if (wc_q == WW'(MRD - 1)) begin
          wc_d = '0;
          st_d = S_DONE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      wc_q   <= '0;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      wc_q   <= wc_d;
      code_q <= code_d;
    end
  end

  assign done = (st_q == S_DONE);
  assign code = code_q;
endmodule

// File: rtl/wlv_sweeper.sv
module wlv_sweeper #(
  parameter int unsigned NGRP     = 8,
  parameter int unsigned CODES    = 32,
  parameter int unsigned NSAMP    = 5,
  parameter int unsigned SETTLE   = 3,
  parameter int unsigned MRD      = 4,
  parameter int unsigned MRA_W    = 3,
  parameter int unsigned MRD_W    = 14,
  parameter int unsigned MR1_ADDR = 1,
  parameter logic [13:0] MR1_BASE = 14'h0001,
  parameter int unsigned LVL_BIT  = 7,
  localparam int unsigned CW      = $clog2(CODES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               mr_wr_o,
  output logic [MRA_W-1:0]   mr_addr_o,
  output logic [MRD_W-1:0]   mr_data_o,
  output logic               pulse_o,
  input  logic [NGRP-1:0]    fb_i,
  output logic [NGRP*CW-1:0] dly_code_o,
  output logic [NGRP-1:0]    err_o,
  output logic               done_o
);
  localparam logic [MRD_W-1:0] LVL_MASK = MRD_W'(1) << LVL_BIT;
  localparam logic [MRD_W-1:0] BASE     = MRD_W'(MR1_BASE);

  logic          mr_on, smp_clr, upd, fin, clr, all_lock;
  logic [CW-1:0] sweep_code;
  logic [NGRP-1:0] vote, hit, locked;

  assign all_lock = &(locked | hit);

  wlv_seq #(
    .CODES (CODES),
    .NSAMP (NSAMP),
    .SETTLE(SETTLE),
    .MRD   (MRD)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .all_lock(all_lock),
    .mr_wr   (mr_wr_o),
    .mr_on   (mr_on),
    .pulse   (pulse_o),
    .smp_clr (smp_clr),
    .upd     (upd),
    .fin     (fin),
    .clr     (clr),
    .done    (done_o),
    .code    (sweep_code)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    wlv_vote #(.NSAMP(NSAMP)) vote_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (smp_clr),
      .smp_en(pulse_o),
      .fb    (fb_i[g]),
      .maj   (vote[g])
    );
    wlv_lane #(.CW(CW)) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .upd       (upd),
      .fin       (fin),
      .vote      (vote[g]),
      .sweep_code(sweep_code),
      .hit       (hit[g]),
      .locked    (locked[g]),
      .err       (err_o[g]),
      .code_o    (dly_code_o[g*CW +: CW])
    );
  end

  assign mr_addr_o = MRA_W'(MR1_ADDR);
  assign mr_data_o = mr_on ? (BASE | LVL_MASK) : (BASE & ~LVL_MASK);
endmodule

// File: rtl/wlv_sweeper_chk.sv
module wlv_sweeper_chk #(
  parameter int unsigned NGRP   = 8,
  parameter int unsigned CW     = 5,
  parameter int unsigned NSAMP  = 5,
  parameter int unsigned SETTLE = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mr_wr_o,
  input logic               pulse_o,
  input logic               done_o,
  input logic [NGRP-1:0]    err_o,
  input logic [NGRP*CW-1:0] dly_code_o
);
  localparam int unsigned AW = $clog2(SETTLE + 1) + 1;
  localparam int unsigned PW = $clog2(NSAMP + 2) + 1;

  logic [NGRP*CW-1:0] prev_q;
  logic [AW-1:0]      age_q, age;
  logic [PW-1:0]      pcnt_q;
  logic               chg;

  assign chg = (dly_code_o != prev_q);
  assign age = chg ? '0 : age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      age_q  <= '0;
      pcnt_q <= '0;
    end else begin
      prev_q <= dly_code_o;
      age_q  <= (age < AW'(SETTLE)) ? age + 1'b1 : age;
      if (chg) pcnt_q <= '0;
      else if (pulse_o && pcnt_q < PW'(NSAMP + 1)) pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assert_settle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (age >= AW'(SETTLE)));

  assert_pulses_per_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && pcnt_q != '0) |-> (pcnt_q == PW'(NSAMP)));

  assert_mr_not_with_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mr_wr_o |-> !pulse_o);

  assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!pulse_o && !mr_wr_o));

  assert_hold_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> ($stable(dly_code_o) && $stable(err_o)));

  for (genvar g = 0; g < NGRP; g++) begin : g_err
    assert_err_parks_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o[g]) |-> (dly_code_o[g*CW +: CW] == '0));
  end
endmodule

bind wlv_sweeper wlv_sweeper_chk #(
  .NGRP  (NGRP),
  .CW    (CW),
  .NSAMP (NSAMP),
  .SETTLE(SETTLE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mr_wr_o   (mr_wr_o),
  .pulse_o   (pulse_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .dly_code_o(dly_code_o)
);

// File: tb/wlv_sweeper_tb_top.sv
`timescale 1ns/1ps
module wlv_sweeper_tb_top;
  localparam int NG = 8;
  localparam int CW = 5;
  localparam int NS = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic            mr_wr_o, pulse_o, done_o;
  logic [2:0]      mr_addr_o;
  logic [13:0]     mr_data_o;
  logic [NG-1:0]   fb_i = '0;
  logic [NG*CW-1:0] dly_code_o;
  logic [NG-1:0]   err_o;

  int n_chk = 0;
  int n_fail = 0;

  // feedback model: fb = code < pre || code >= edge
  int edge_v [NG];
  int pre_v  [NG];
  int gl_grp = -1, gl_code = -1, gl_left = 0;
  int mr_cnt = 0;
  logic [13:0] mr_dat [4];
  logic [2:0]  mr_adr [4];
  int pulse_cnt = 0;
  int pulse_before_mr = 0;
  int nonzero_at_pulse = 0;

  always #5 clk = ~clk;

  wlv_sweeper dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mr_wr_o(mr_wr_o), .mr_addr_o(mr_addr_o), .mr_data_o(mr_data_o),
    .pulse_o(pulse_o), .fb_i(fb_i), .dly_code_o(dly_code_o),
    .err_o(err_o), .done_o(done_o)
  );

  function automatic int code_of(int g);
    return int'(dly_code_o[g*CW +: CW]);
  endfunction

  always @(negedge clk) begin
    if (mr_wr_o) begin
      if (mr_cnt < 4) begin
        mr_dat[mr_cnt] = mr_data_o;
        mr_adr[mr_cnt] = mr_addr_o;
      end
      mr_cnt++;
    end
    if (pulse_o) begin
      pulse_cnt++;
      if (mr_cnt == 0) pulse_before_mr++;
      if (mr_cnt == 1 && pulse_cnt == 1 && dly_code_o != '0) nonzero_at_pulse++;
    end
    for (int g = 0; g < NG; g++) begin
      int c;
      logic b;
      c = code_of(g);
      b = (c < pre_v[g]) || (c >= edge_v[g]);
      if (pulse_o && g == gl_grp && c == gl_code && gl_left > 0) begin
        b = ~b;
        gl_left--;
      end
      fb_i[g] = b;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    mr_cnt = 0; pulse_cnt = 0; pulse_before_mr = 0; nonzero_at_pulse = 0;
  endtask

  task automatic kick();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 2000) begin @(negedge clk); n++; end
    chk(done_o, {tag, " watchdog"}, 0, 1);
  endtask

  task automatic check_codes(input string req, input int exp [NG]);
    for (int g = 0; g < NG; g++) chk(code_of(g) == exp[g], req, code_of(g), exp[g]);
  endtask

  task automatic t_reset();
    chk(done_o == 0, "R1 done", done_o, 0);
    chk(err_o == 0, "R1 err", err_o, 0);
    chk(mr_wr_o == 0 && pulse_o == 0, "R1 strobes", {mr_wr_o, pulse_o}, 0);
    chk(dly_code_o == 0, "R1 codes", 1, 0);
  endtask

  task automatic t_normal();
    int e [NG] = '{3, 10, 17, 31, 1, 8, 22, 5};
    for (int g = 0; g < NG; g++) begin edge_v[g] = e[g]; pre_v[g] = 0; end
    clear_mon();
    kick();
    wait_done("R7 normal");
    check_codes("R5 normal lock", e);
    chk(err_o == 0, "R6 no error", err_o, 0);
    chk(mr_cnt == 2, "R7 mode write count", mr_cnt, 2);
    chk(mr_adr[0] == 1 && mr_adr[1] == 1, "R2 mode address", mr_adr[0], 1);
    chk(mr_dat[0] == 14'h0081, "R2 enter data", mr_dat[0], 'h81);
    chk(mr_dat[1] == 14'h0001, "R7 exit data", mr_dat[1], 'h01);
    chk(pulse_before_mr == 0, "R2 enter before pulses", pulse_before_mr, 0);
    chk(nonzero_at_pulse == 0, "R2 codes zero at first pulse", nonzero_at_pulse, 0);
    chk(pulse_cnt == 32 * NS, "R3 R4 full sweep pulses", pulse_cnt, 32 * NS);
  endtask

  task automatic t_errors();
    int e [NG] = '{0, 32, 4, 4, 4, 4, 4, 31};
    int x [NG] = '{0, 0, 4, 4, 4, 4, 4, 31};
    for (int g = 0; g < NG; g++) begin edge_v[g] = e[g]; pre_v[g] = 0; end
    clear_mon();
    kick();
    wait_done("R6 errors");
    chk(err_o == 8'b0000_0011, "R6 error bits", err_o, 3);
    check_codes("R6 error codes", x);
  endtask

  task automatic t_early_and_noise();
    int e [NG] = '{12, 2, 6, 9, 1, 12, 7, 3};
    for (int g = 0; g < NG; g++) begin edge_v[g] = e[g]; pre_v[g] = 0; end
    gl_grp = 0; gl_code = 6; gl_left = 2;   // two wrong samples of five at code 6
    clear_mon();
    kick();
    wait_done("R4 noise");
    check_codes("R4 R5 noise rejected", e);
    chk(pulse_cnt == 13 * NS, "R7 early end pulses", pulse_cnt, 13 * NS);
    chk(gl_left == 0, "R4 glitches applied", gl_left, 0);
    gl_grp = -1;
  endtask

  task automatic t_nonmono();
    int e [NG] = '{9, 5, 5, 5, 5, 5, 5, 5};
    for (int g = 0; g < NG; g++) begin edge_v[g] = e[g]; pre_v[g] = 0; end
    pre_v[0] = 4;   // high at codes 0..3, low 4..8, high from 9
    clear_mon();
    kick();
    wait_done("R5 nonmono");
    check_codes("R5 first rising transition", e);
    chk(err_o == 0, "R5 nonmono no error", err_o, 0);
  endtask

  task automatic t_start_busy_and_hold();
    int e [NG] = '{20, 20, 20, 20, 20, 20, 20, 21};
    logic [NG*CW-1:0] snap;
    for (int g = 0; g < NG; g++) begin edge_v[g] = e[g]; pre_v[g] = 0; end
    clear_mon();
    kick();
    repeat (60) @(negedge clk);
    kick();   // must be ignored mid-sweep
    wait_done("R8 busy start");
    chk(mr_cnt == 2, "R8 busy start ignored", mr_cnt, 2);
    check_codes("R8 codes after ignored start", e);
    snap = dly_code_o;
    repeat (20) @(negedge clk);
    chk(done_o == 1, "R8 done held", done_o, 1);
    chk(dly_code_o == snap, "R8 codes held", 0, 0);
    kick();
    chk(done_o == 0, "R8 restart clears done", done_o, 0);
    wait_done("R8 restart");
    check_codes("R8 restart result", e);
  endtask

  initial begin
    for (int g = 0; g < NG; g++) begin edge_v[g] = 32; pre_v[g] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_errors();
    t_early_and_noise();
    t_nonmono();
    t_start_busy_and_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule